// File: doc/BRIEF.md
# Write-Update Snooping Cache Coherence Controller

This block keeps one small write-back cache coherent with its peers on a shared snooping bus. It uses an update policy: a write to data that other caches also hold sends the single written word over the bus, and those caches overwrite their copy. They do not drop the line. Each present line holds one of four states:

- `EXCL`: clean, and no other cache holds it.
- `SHCLEAN`: clean, and other caches may hold it.
- `SHMOD`: this cache owns dirty data that other caches share, and memory is stale.
- `DIRTY`: modified, and no other cache holds it.

There is no invalid state for a present line. A miss is handled by a separate read-miss or write-miss path.

The processor presents one request at a time and holds it until `cpu_done` pulses. The controller raises `bus_req` with a command and waits for `bus_gnt`. A granted transaction completes in that cycle. In the same cycle the peers' wired-OR sharing vote arrives on `bus_shared_in`, and line fill data arrives on `bus_fill`.

Peer transactions enter on the snoop port. The block answers them combinationally: `snp_shared_out` asserts when this cache holds the line, and `snp_flush` asserts when it must supply the line. A snoop cycle takes precedence over the start of a processor request. The cache is direct-mapped. An address splits as {tag, index, word offset}, with the tag in the upper bits.

Top module: `dragon_cache_ctl`

## Requirements
- R1: After reset no line is present, `bus_req` and `cpu_done` are low, a snooped read sees `snp_shared_out` low, and the first processor access issues a bus read.
- R2: On a read miss the block issues a bus read (command code 1) at the line-aligned address. The line becomes `EXCL` if `bus_shared_in` is low, or `SHCLEAN` if it is high. The read returns word k of `bus_fill`, which sits at bits [k*DATA_W +: DATA_W].
- R3: On a write miss the block issues a bus read. If the sharing vote is high, it then issues an update (code 2) of the written word and ends in `SHMOD`. If the vote is low, no update is issued and the line ends in `DIRTY`.
- R4: A write hit in `SHCLEAN` or `SHMOD` issues one update (code 2) at the word address, then goes to `SHMOD` if the vote is high or to `DIRTY` if it is low. A write hit in `EXCL` or `DIRTY` completes with no bus request and leaves the line `DIRTY`.
- R5: A read hit completes with no bus request and returns the stored word.
- R6: On a write hit to shared data, the local copy keeps its old word until the update is granted. A flush that a snoop triggers while the update waits carries the old word.
- R7: A snooped update (code 2) to a held line overwrites the addressed word and leaves the line `SHCLEAN`, which demotes a `SHMOD` owner. A snooped update to a line that is not held changes nothing.
- R8: A snooped read (code 1) of a held line asserts `snp_shared_out`. A `DIRTY` or `SHMOD` line also asserts `snp_flush`, drives its whole line on `snp_line`, and ends in `SHMOD`. An `EXCL` line drops to `SHCLEAN` and does not flush.
- R9: A miss whose victim is `DIRTY` or `SHMOD` first writes the victim back (code 3) at the victim's line address, then issues the bus read. A clean victim is replaced with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 none, 1 read, 2 update, 3 flush/writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_word | output | DATA_W | Word carried by an update |
| bus_line | output | LINE_W | Line carried by a writeback |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_shared_in | input | 1 | Wired-OR sharing vote from the peers |
| bus_fill | input | LINE_W | Fill line for a bus read |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Peer command, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Peer address |
| snp_word | input | DATA_W | Word carried by a peer update |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies the snooped line |
| snp_line | output | LINE_W | Line supplied on a flush |

## Verification
A wrong line state is not visible when it is set. It shows at the ports on the next operation that touches the line.

- `EXCL` or `DIRTY` held where `SHCLEAN` belongs: a later write hit makes no update where one is due.
- `SHCLEAN` held where an owner state belongs: a later snooped read or a replacement makes no flush.
- A word written too early: the stale-word flush in the update window carries the new data.

The bench therefore follows each state-setting access with a probe of the same line, either a write hit, a snooped read or an evicting miss. Each error then shows within a few cycles.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [1:0] {
    LS_EXCL    = 2'd0,
    LS_SHCLEAN = 2'd1,
    LS_SHMOD   = 2'd2,
    LS_DIRTY   = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_FLUSH  = 2'd3
  } bus_cmd_t;

  // State after a bus read fill, chosen by the sharing vote.
  function automatic line_st_t st_after_fill(input logic shared);
    return shared ? LS_SHCLEAN : LS_EXCL;
  endfunction

  // State after this cache's own update broadcast.
  function automatic line_st_t st_after_update(input logic shared);
    return shared ? LS_SHMOD : LS_DIRTY;
  endfunction

  // The line holds data newer than memory.
  function automatic logic is_owner(input line_st_t st);
    return (st == LS_DIRTY) || (st == LS_SHMOD);
  endfunction

  // Transition of a held line when a peer transaction hits it.
  function automatic line_st_t st_after_snoop(input line_st_t st, input bus_cmd_t cmd);
    case (cmd)
      BC_UPDATE: return LS_SHCLEAN;
      BC_READ:   return is_owner(st) ? LS_SHMOD : LS_SHCLEAN;
      default:   return st;
    endcase
  endfunction

endpackage

// File: rtl/dragon_line_store.sv
module dragon_line_store
  import dragon_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side read port
  input  logic [IDX_W-1:0]  pa_idx,
  output logic              pa_present,
  output logic [TAG_W-1:0]  pa_tag,
  output line_st_t          pa_state,
  output logic [LINE_W-1:0] pa_line,
  // snoop-side read port
  input  logic [IDX_W-1:0]  sb_idx,
  output logic              sb_present,
  output logic [TAG_W-1:0]  sb_tag,
  output line_st_t          sb_state,
  output logic [LINE_W-1:0] sb_line,
  // processor-side write
  input  logic              pw_en,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic              pw_present,
  input  logic [TAG_W-1:0]  pw_tag,
  input  line_st_t          pw_state,
  input  logic [LINE_W-1:0] pw_line,
  // snoop-side write
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_state,
  input  logic [LINE_W-1:0] sw_line
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  present_v;
  logic [TAG_W-1:0]  tag_v   [LINES];
  line_st_t          state_v [LINES];
  logic [LINE_W-1:0] data_v  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              present_q;
    logic [TAG_W-1:0]  tag_q;
    line_st_t          state_q;
    logic [LINE_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present_q <= 1'b0;
        tag_q     <= '0;
        state_q   <= LS_EXCL;
        data_q    <= '0;
      end else if (pw_en && pw_idx == IDX_W'(g)) begin
        present_q <= pw_present;
        tag_q     <= pw_tag;
        state_q   <= pw_state;
        data_q    <= pw_line;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        state_q   <= sw_state;
        data_q    <= sw_line;
      end
    end

    assign present_v[g] = present_q;
    assign tag_v[g]     = tag_q;
    assign state_v[g]   = state_q;
    assign data_v[g]    = data_q;
  end

  assign pa_present = present_v[pa_idx];
  assign pa_tag     = tag_v[pa_idx];
  assign pa_state   = state_v[pa_idx];
  assign pa_line    = data_v[pa_idx];

  assign sb_present = present_v[sb_idx];
  assign sb_tag     = tag_v[sb_idx];
  assign sb_state   = state_v[sb_idx];
  assign sb_line    = data_v[sb_idx];
endmodule

// File: rtl/dragon_snoop_resp.sv
module dragon_snoop_resp
  import dragon_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  localparam int LINE_W = DATA_W << OFF_W
) (
  input  logic              snp_valid,
  input  bus_cmd_t          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [OFF_W-1:0]  snp_off,
  input  logic [DATA_W-1:0] snp_word,
  input  logic              ln_present,
  input  logic [TAG_W-1:0]  ln_tag,
  input  line_st_t          ln_state,
  input  logic [LINE_W-1:0] ln_data,
  output logic              shared_out,
  output logic              flush,
  output logic              upd_en,
  output line_st_t          upd_state,
  output logic [LINE_W-1:0] upd_data
);
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[o*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  logic relevant, hit;

  always_comb begin
    relevant   = snp_valid && (snp_cmd == BC_READ || snp_cmd == BC_UPDATE);
    hit        = relevant && ln_present && (ln_tag == snp_tag);
    shared_out = hit;
    flush      = hit && (snp_cmd == BC_READ) && is_owner(ln_state);
    upd_en     = hit;
    upd_state  = st_after_snoop(ln_state, snp_cmd);
    upd_data   = (snp_cmd == BC_UPDATE) ? put_word(ln_data, snp_off, snp_word) : ln_data;
  end
endmodule

// File: rtl/dragon_cache_ctl.sv
module dragon_cache_ctl
  import dragon_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
  localparam int LINE_W = DATA_W << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_word,
  output logic [LINE_W-1:0] bus_line,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [LINE_W-1:0] bus_fill,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_word,
  output logic              snp_shared_out,
  output logic              snp_flush,
  output logic [LINE_W-1:0] snp_line
);
  typedef enum logic [1:0] {CS_IDLE, CS_WBACK, CS_FETCH, CS_UPD} ctl_t;

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] o);
    return ln[o*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [OFF_W-1:0] o,
                                                 input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[o*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  // address fields
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [IDX_W-1:0] c_idx, s_idx;
  logic [OFF_W-1:0] c_off, s_off;
  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_off = cpu_addr[OFF_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign s_idx = snp_addr[OFF_W +: IDX_W];
  assign s_off = snp_addr[OFF_W-1:0];

  ctl_t              ctl_q, ctl_d;
  logic              done_d;
  logic [DATA_W-1:0] rdata_d;

  logic              c_present, s_present;
  logic [TAG_W-1:0]  c_tag_q, s_tag_q;
  line_st_t          c_state, s_state;
  logic [LINE_W-1:0] c_line, s_line;

  logic              pw_en, pw_present;
  logic [TAG_W-1:0]  pw_tag;
  line_st_t          pw_state;
  logic [LINE_W-1:0] pw_line;
  logic              sw_en;
  line_st_t          sw_state;
  logic [LINE_W-1:0] sw_line;

  dragon_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pa_idx(c_idx), .pa_present(c_present), .pa_tag(c_tag_q), .pa_state(c_state), .pa_line(c_line),
    .sb_idx(s_idx), .sb_present(s_present), .sb_tag(s_tag_q), .sb_state(s_state), .sb_line(s_line),
    .pw_en(pw_en), .pw_idx(c_idx), .pw_present(pw_present), .pw_tag(pw_tag),
    .pw_state(pw_state), .pw_line(pw_line),
    .sw_en(sw_en), .sw_idx(s_idx), .sw_state(sw_state), .sw_line(sw_line)
  );

  dragon_snoop_resp #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_tag(s_tag), .snp_off(s_off),
    .snp_word(snp_word), .ln_present(s_present), .ln_tag(s_tag_q), .ln_state(s_state),
    .ln_data(s_line), .shared_out(snp_shared_out), .flush(snp_flush), .upd_en(sw_en),
    .upd_state(sw_state), .upd_data(sw_line)
  );
  assign snp_line = s_line;

  // named processor-side events
  logic accept, c_hit, ev_rd_hit, ev_wr_local, ev_wr_bcast, ev_miss_owner, ev_miss_clean;
  assign accept        = (ctl_q == CS_IDLE) && cpu_req && !snp_valid && !cpu_done;
  assign c_hit         = c_present && (c_tag_q == c_tag);
  assign ev_rd_hit     = accept && c_hit && !cpu_we;
  assign ev_wr_local   = accept && c_hit && cpu_we && (c_state == LS_EXCL || c_state == LS_DIRTY);
  assign ev_wr_bcast   = accept && c_hit && cpu_we && (c_state == LS_SHCLEAN || c_state == LS_SHMOD);
  assign ev_miss_owner = accept && !c_hit && c_present && is_owner(c_state);
  assign ev_miss_clean = accept && !c_hit && !(c_present && is_owner(c_state));

  // bus outputs follow the controller state
  always_comb begin
    bus_req  = (ctl_q != CS_IDLE);
    bus_word = cpu_wdata;
    bus_line = c_line;
    case (ctl_q)
      CS_WBACK: begin bus_cmd = BC_FLUSH;  bus_addr = {c_tag_q, c_idx, {OFF_W{1'b0}}}; end
      CS_FETCH: begin bus_cmd = BC_READ;   bus_addr = {c_tag,   c_idx, {OFF_W{1'b0}}}; end
      CS_UPD:   begin bus_cmd = BC_UPDATE; bus_addr = cpu_addr; end
      default:  begin bus_cmd = BC_NONE;   bus_addr = '0; end
    endcase
  end

  always_comb begin
    ctl_d      = ctl_q;
    done_d     = 1'b0;
    rdata_d    = cpu_rdata;
    pw_en      = 1'b0;
    pw_present = 1'b1;
    pw_tag     = c_tag;
    pw_state   = c_state;
    pw_line    = c_line;
    case (ctl_q)
      CS_IDLE: begin
        if (ev_rd_hit) begin
          done_d  = 1'b1;
          rdata_d = get_word(c_line, c_off);
        end else if (ev_wr_local) begin
          pw_en    = 1'b1;
          pw_state = LS_DIRTY;
          pw_line  = put_word(c_line, c_off, cpu_wdata);
          done_d   = 1'b1;
        end else if (ev_wr_bcast) begin
          ctl_d = CS_UPD;
        end else if (ev_miss_owner) begin
          ctl_d = CS_WBACK;
        end else if (ev_miss_clean) begin
          ctl_d = CS_FETCH;
        end
      end
      CS_WBACK: if (bus_gnt) begin
        pw_en      = 1'b1;
        pw_present = 1'b0;
        pw_tag     = c_tag_q;
        ctl_d      = CS_FETCH;
      end
      CS_FETCH: if (bus_gnt) begin
        pw_en   = 1'b1;
        pw_line = bus_fill;
        if (!cpu_we) begin
          pw_state = st_after_fill(bus_shared_in);
          done_d   = 1'b1;
          rdata_d  = get_word(bus_fill, c_off);
          ctl_d    = CS_IDLE;
        end else if (bus_shared_in) begin
          pw_state = LS_SHCLEAN;
          ctl_d    = CS_UPD;
        end else begin
          pw_state = LS_DIRTY;
          pw_line  = put_word(bus_fill, c_off, cpu_wdata);
          done_d   = 1'b1;
          ctl_d    = CS_IDLE;
        end
      end
      CS_UPD: if (bus_gnt) begin
        pw_en    = 1'b1;
        pw_state = st_after_update(bus_shared_in);
        pw_line  = put_word(c_line, c_off, cpu_wdata);
        done_d   = 1'b1;
        ctl_d    = CS_IDLE;
      end
      default: ctl_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= CS_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      ctl_q     <= ctl_d;
      cpu_done  <= done_d;
      cpu_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/dragon_cache_ctl_chk.sv
module dragon_cache_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_we,
  input logic       cpu_done,
  input logic       bus_req,
  input logic [1:0] bus_cmd,
  input logic       bus_gnt,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_shared_out,
  input logic       snp_flush,
  input logic       ev_rd_hit
);
  a_r2_read_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd1 && !cpu_we) |=> cpu_done);

  a_r4_update_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |=> cpu_done);

  a_r5_read_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hit |=> (cpu_done && !bus_req));

  a_r8_flush_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && snp_cmd == 2'd1 && snp_shared_out));

  a_r9_writeback_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (bus_req && bus_cmd == 2'd1));

  a_r1_req_has_command: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd != 2'd0));
endmodule

bind dragon_cache_ctl dragon_cache_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_shared_out(snp_shared_out),
  .snp_flush(snp_flush), .ev_rd_hit(ev_rd_hit)
);

// File: tb/dragon_cache_ctl_bench.sv
module dragon_cache_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic [15:0] bus_fill = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [6:0]  snp_addr = '0;
  logic [7:0]  snp_word = '0;
  logic        cpu_done, bus_req, snp_shared_out, snp_flush;
  logic [7:0]  cpu_rdata, bus_word;
  logic [1:0]  bus_cmd;
  logic [6:0]  bus_addr;
  logic [15:0] bus_line, snp_line;

  dragon_cache_ctl u_dragon_cache_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_word(bus_word),
    .bus_line(bus_line), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_fill(bus_fill),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_word(snp_word),
    .snp_shared_out(snp_shared_out), .snp_flush(snp_flush), .snp_line(snp_line)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] mem [128];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  default: return "R9";
    endcase
  endfunction

  // Bench is also the bus: grants at once and models memory
  task automatic do_cpu(input logic we, input logic [6:0] a, input logic [7:0] wd, input logic sh,
                        output logic [5:0] tr, output logic [7:0] rd);
    tr = '0; rd = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (cpu_done) begin rd = cpu_rdata; break; end
      if (bus_req) begin
        bus_gnt = 1'b1; bus_shared_in = sh;
        bus_fill = {mem[{bus_addr[6:1], 1'b1}], mem[{bus_addr[6:1], 1'b0}]};
        tr = {tr[3:0], bus_cmd};
        if (bus_cmd == 2'd3) begin
          mem[{bus_addr[6:1], 1'b0}] = bus_line[7:0];
          mem[{bus_addr[6:1], 1'b1}] = bus_line[15:8];
        end
      end else bus_gnt = 1'b0;
    end
    cpu_req = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [6:0] a, input logic [7:0] w,
                       output logic sh, output logic fl, output logic [15:0] ln);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_word = w;
    #1;
    sh = snp_shared_out; fl = snp_flush; ln = snp_line;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = '0;
  endtask

  // {req[34:31], we[30], addr[29:23], wdata[22:15], shared[14], trace[13:8], rdata[7:0]}
  // trace: bus commands in issue order, two bits each, newest in the low bits
  localparam logic [34:0] VEC [16] = '{
    {4'd1, 1'b0, 7'd8,  8'h00, 1'b0, 6'd1,  8'h19},
    {4'd4, 1'b1, 7'd9,  8'hAA, 1'b0, 6'd0,  8'h00},
    {4'd5, 1'b0, 7'd9,  8'h00, 1'b0, 6'd0,  8'hAA},
    {4'd2, 1'b0, 7'd10, 8'h00, 1'b1, 6'd1,  8'h1F},
    {4'd4, 1'b1, 7'd11, 8'h55, 1'b1, 6'd2,  8'h00},
    {4'd5, 1'b0, 7'd11, 8'h00, 1'b0, 6'd0,  8'h55},
    {4'd4, 1'b1, 7'd10, 8'h66, 1'b0, 6'd2,  8'h00},
    {4'd4, 1'b1, 7'd10, 8'h67, 1'b0, 6'd0,  8'h00},
    {4'd3, 1'b1, 7'd12, 8'h77, 1'b1, 6'd6,  8'h00},
    {4'd3, 1'b1, 7'd14, 8'h88, 1'b0, 6'd1,  8'h00},
    {4'd9, 1'b0, 7'd16, 8'h00, 1'b0, 6'd13, 8'h31},
    {4'd9, 1'b0, 7'd8,  8'h00, 1'b0, 6'd1,  8'h19},
    {4'd9, 1'b0, 7'd9,  8'h00, 1'b0, 6'd0,  8'hAA},
    {4'd9, 1'b0, 7'd18, 8'h00, 1'b0, 6'd13, 8'h37},
    {4'd9, 1'b0, 7'd10, 8'h00, 1'b0, 6'd1,  8'h67},
    {4'd5, 1'b0, 7'd11, 8'h00, 1'b0, 6'd0,  8'h55}
  };

  initial begin
    logic [5:0] tr; logic [7:0] rd;
    logic sh, fl; logic [15:0] ln;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus_req after reset", 32'(bus_req), 0);
    chk("R1", "cpu_done after reset", 32'(cpu_done), 0);
    snoop(2'd1, 7'd8, 8'h00, sh, fl, ln);
    chk("R1", "shared on empty cache", 32'(sh), 0);

    for (int v = 0; v < 16; v++) begin
      do_cpu(VEC[v][30], VEC[v][29:23], VEC[v][22:15], VEC[v][14], tr, rd);
      chk(rname(VEC[v][34:31]), $sformatf("vector %0d bus trace", v), 32'(tr), 32'(VEC[v][13:8]));
      if (!VEC[v][30])
        chk(rname(VEC[v][34:31]), $sformatf("vector %0d read data", v), 32'(rd), 32'(VEC[v][7:0]));
    end

    // R8: owners flush and stay owners; exclusive demotes silently
    snoop(2'd1, 7'd12, 8'h00, sh, fl, ln);
    chk("R8", "SHMOD flush", {30'd0, sh, fl}, 3);
    chk("R8", "SHMOD flushed line", 32'(ln), 32'h2877);
    snoop(2'd1, 7'd12, 8'h00, sh, fl, ln);
    chk("R8", "SHMOD still owner", 32'(fl), 1);
    snoop(2'd1, 7'd14, 8'h00, sh, fl, ln);
    chk("R8", "DIRTY flush", {30'd0, sh, fl}, 3);
    chk("R8", "DIRTY flushed line", 32'(ln), 32'h2E88);
    snoop(2'd1, 7'd14, 8'h00, sh, fl, ln);
    chk("R8", "DIRTY became SHMOD", 32'(fl), 1);
    snoop(2'd1, 7'd8, 8'h00, sh, fl, ln);
    chk("R8", "EXCL shares without flush", {30'd0, sh, fl}, 2);
    do_cpu(1'b1, 7'd8, 8'h11, 1'b1, tr, rd);
    chk("R8", "EXCL demoted, write now broadcasts", 32'(tr), 2);
    snoop(2'd1, 7'd40, 8'h00, sh, fl, ln);
    chk("R8", "absent line no response", {30'd0, sh, fl}, 0);

    // R7: snooped update overwrites word and demotes owner
    snoop(2'd2, 7'd9, 8'h99, sh, fl, ln);
    chk("R7", "update hit shared vote", {30'd0, sh, fl}, 2);
    do_cpu(1'b0, 7'd9, 8'h00, 1'b0, tr, rd);
    chk("R7", "updated word read", {18'd0, tr, rd}, 32'h0099);
    snoop(2'd1, 7'd8, 8'h00, sh, fl, ln);
    chk("R7", "SHMOD demoted to SHCLEAN", {30'd0, sh, fl}, 2);
    snoop(2'd2, 7'd41, 8'hEE, sh, fl, ln);
    chk("R7", "update to absent line", 32'(sh), 0);
    do_cpu(1'b0, 7'd9, 8'h00, 1'b0, tr, rd);
    chk("R7", "absent update left data", 32'(rd), 32'h99);

    // R6: write held until the update is granted
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 7'd12; cpu_wdata = 8'h5A; bus_gnt = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6", "update pending", {23'd0, bus_req, bus_cmd, bus_addr}, {23'd0, 1'b1, 2'd2, 7'd12});
    end
    snoop(2'd1, 7'd12, 8'h00, sh, fl, ln);
    chk("R6", "flush carries old word", {15'd0, fl, ln}, {15'd0, 1'b1, 16'h2877});
    bus_gnt = 1'b1; bus_shared_in = 1'b0;
    @(negedge clk);
    chk("R4", "update granted completes", 32'(cpu_done), 1);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    do_cpu(1'b0, 7'd12, 8'h00, 1'b0, tr, rd);
    chk("R6", "new word after grant", {18'd0, tr, rd}, 32'h005A);
    do_cpu(1'b1, 7'd13, 8'h3C, 1'b0, tr, rd);
    chk("R4", "DIRTY after unshared update, silent write", 32'(tr), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule